// File: doc/BRIEF.md
# Time-of-Day Counter with Frequency Trimming

This block keeps a seconds and sub-seconds clock of day that moves forward on every reference clock edge. Each time the counter is allowed to step, the sub-second field grows by a programmed 8-bit increment. In coarse mode it steps on every cycle. In fine mode a 32-bit phase accumulator adds an active addend on every cycle, and the counter steps only on cycles where that sum carries out of bit 31. Software trims the clock rate by choosing the addend. For example, an addend of 2^31 gives one step every two cycles, so the increment should then be twice the clock period.

The sub-second field wraps in one of two ways. In decimal form it counts nanoseconds and wraps at 10^9. In binary form it wraps at 2^31, with one unit worth about 0.465 ns. The wrap carries into seconds in the same cycle. Software uses three self-clearing command bits: one loads an absolute time, one applies a signed offset, and one makes a staged addend the active addend. All access goes through a single-cycle bus. Writes take effect at the clock edge. Reads return the addressed word registered one cycle later, and seconds and sub-seconds always change together.

Top module: `tod_counter`

## Requirements
- R1: While reset is high and at the first edge after it, every register, the time, the accumulator and `rd_data` are zero.
- R2: Word 1 holds the 8-bit increment. In coarse mode (word 0 bit 0 = 0), the sub-second field grows by that increment on every cycle that runs no command.
- R3: In fine mode (word 0 bit 0 = 1), a 32-bit accumulator adds the active addend on every cycle. The time steps only on cycles where this addition carries out.
- R4: In decimal mode (word 0 bit 1 = 1), the sub-second field wraps at 10^9. Seconds go up by one in the same cycle.
- R5: In binary mode (word 0 bit 1 = 0), the sub-second field wraps at 2^31. Seconds go up by one in the same cycle.
- R6: Writing word 0 with bit 2 set loads seconds from word 2 and sub-seconds from word 3 bits 30:0 at the next edge. Bit 2 reads back as 1 until that edge.
- R7: Word 0 bit 3 adds the offset in words 2 and 3 to the time when word 3 bit 31 is 0. A sub-second carry goes into seconds.
- R8: When word 3 bit 31 is 1, software writes word 2 as 2^32 minus s and word 3 bits 30:0 as the wrap value minus n. The command then subtracts s seconds and n sub-seconds, including the borrow from seconds.
- R9: Word 0 bit 4 copies the staged addend in word 4 into the active addend at the next edge. The new addend is used from the following cycle.
- R10: One command runs per cycle, chosen in the order load (bit 2), then offset (bit 3), then addend copy (bit 4). Each pending bit clears in the cycle its command runs. A cycle that runs a load or an offset does not step the time.
- R11: With `INC_SHIFTED` = 0 the increment sits in word 1 bits 7:0. With `INC_SHIFTED` = 1 it sits in bits 23:16.
- R12: `rd_data` shows the word at `rd_addr` as it stood at the previous edge. Word 5 is seconds, word 6 is sub-seconds and word 7 reads as zero. A wrap updates both time words at the same edge, so a seconds read that follows a sub-seconds read shows the new second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Word address for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Word address for reads |
| rd_data | output | 32 | Registered read data |

## Verification
A write changes the register state at the edge where `wr_en` is sampled. A pending command runs at the next edge, and `rd_data` shows any state one edge after the address is presented. The bench's behavioural model uses the same schedule. On every rising edge it captures the value expected for the presented read address from its state before that edge, then advances its state. It compares the design output at the falling edge. The read address cycles through every word, so command bits are seen while they are pending and while they clear, and wrap carries and offset borrows are checked in the cycle they occur.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 3;
  localparam int SUB_W  = 31;
  localparam logic [WORD_W-1:0] WRAP_DEC = 32'd1_000_000_000;
  localparam logic [WORD_W-1:0] WRAP_BIN = 32'h8000_0000;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_INC    = 3'd1;
  localparam logic [ADDR_W-1:0] A_OFFSEC = 3'd2;
  localparam logic [ADDR_W-1:0] A_OFFSUB = 3'd3;
  localparam logic [ADDR_W-1:0] A_ADDEND = 3'd4;
  localparam logic [ADDR_W-1:0] A_TSEC   = 3'd5;
  localparam logic [ADDR_W-1:0] A_TSUB   = 3'd6;

  localparam int B_FINE = 0;
  localparam int B_DEC  = 1;
  localparam int B_LOAD = 2;
  localparam int B_OFFS = 3;
  localparam int B_ADDC = 4;

  typedef struct packed {
    logic load;
    logic offs;
    logic addc;
  } cmd_t;
endpackage

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int INC_W = 8,
  parameter int INC_POS = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] t_sec,
  input  logic [SUB_W-1:0]  t_sub,
  output logic              fine,
  output logic              dec,
  output logic [INC_W-1:0]  inc,
  output logic [WORD_W-1:0] off_sec,
  output logic [SUB_W-1:0]  off_sub,
  output logic              off_neg,
  output logic [WORD_W-1:0] addend_stage,
  output cmd_t              run,
  output logic [WORD_W-1:0] rd_data
);
  cmd_t pend_q;
  logic ctrl_wr;

  assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  assign run.load = pend_q.load;
  assign run.offs = pend_q.offs && !pend_q.load;
  assign run.addc = pend_q.addc && !pend_q.load && !pend_q.offs;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q       <= '0;
      fine         <= 1'b0;
      dec          <= 1'b0;
      inc          <= '0;
      off_sec      <= '0;
      off_sub      <= '0;
      off_neg      <= 1'b0;
      addend_stage <= '0;
    end else begin
      pend_q <= pend_q & ~run;
      if (ctrl_wr) begin
        fine   <= wr_data[B_FINE];
        dec    <= wr_data[B_DEC];
        pend_q <= (pend_q & ~run) |
                  {wr_data[B_LOAD], wr_data[B_OFFS], wr_data[B_ADDC]};
      end
      if (wr_en && wr_addr == A_INC)    inc <= wr_data[INC_POS +: INC_W];
      if (wr_en && wr_addr == A_OFFSEC) off_sec <= wr_data;
      if (wr_en && wr_addr == A_OFFSUB) begin
        off_sub <= wr_data[SUB_W-1:0];
        off_neg <= wr_data[WORD_W-1];
      end
      if (wr_en && wr_addr == A_ADDEND) addend_stage <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        A_CTRL:   rd_data <= {27'd0, pend_q.addc, pend_q.offs, pend_q.load, dec, fine};
        A_INC:    rd_data <= WORD_W'(inc) << INC_POS;
        A_OFFSEC: rd_data <= off_sec;
        A_OFFSUB: rd_data <= {off_neg, off_sub};
        A_ADDEND: rd_data <= addend_stage;
        A_TSEC:   rd_data <= t_sec;
        A_TSUB:   rd_data <= {1'b0, t_sub};
        default:  rd_data <= '0;
      endcase
    end
  end

  AST_OFFS_WAITS: assert property (@(posedge clk) disable iff (rst)
    (pend_q.load && pend_q.offs) |=> pend_q.offs); // R10
  AST_ADDC_WAITS: assert property (@(posedge clk) disable iff (rst)
    (pend_q.addc && (pend_q.load || pend_q.offs)) |=> pend_q.addc); // R10
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (pend_q.load && !(ctrl_wr && wr_data[B_LOAD])) |=> !pend_q.load); // R6
endmodule

// File: rtl/tod_rate.sv
module tod_rate
  import tod_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fine,
  input  logic             take_addend,
  input  logic [ACC_W-1:0] addend_stage,
  output logic             step
);
  logic [ACC_W-1:0] acc_q, addend_q;
  logic [ACC_W:0]   acc_sum;

  assign acc_sum = {1'b0, acc_q} + {1'b0, addend_q};
  assign step    = fine ? acc_sum[ACC_W] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      addend_q <= '0;
    end else begin
      if (fine) acc_q <= acc_sum[ACC_W-1:0];
      if (take_addend) addend_q <= addend_stage;
    end
  end

  AST_ADDEND_TAKEN: assert property (@(posedge clk) disable iff (rst)
    take_addend |=> (addend_q == $past(addend_stage))); // R9
  AST_ZERO_ADDEND_HALTS: assert property (@(posedge clk) disable iff (rst)
    (fine && addend_q == '0) |-> !step); // R3
  AST_FINE_ACC_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (fine && !step) |=> (acc_q == $past(acc_q) + $past(addend_q))); // R3
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int INC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec,
  input  logic [INC_W-1:0]  inc,
  input  logic              step,
  input  logic              do_load,
  input  logic              do_offs,
  input  logic [WORD_W-1:0] off_sec,
  input  logic [SUB_W-1:0]  off_sub,
  input  logic              off_neg,
  output logic [WORD_W-1:0] sec_q,
  output logic [SUB_W-1:0]  sub_q
);
  logic [WORD_W-1:0] wrap_val, tick_sum, offs_sum, sec_adj;
  logic              tick_wrap, offs_wrap;

  assign wrap_val  = dec ? WRAP_DEC : WRAP_BIN;
  assign tick_sum  = {1'b0, sub_q} + WORD_W'(inc);
  assign tick_wrap = tick_sum >= wrap_val;
  assign offs_sum  = {1'b0, sub_q} + {1'b0, off_sub};
  assign offs_wrap = offs_sum >= wrap_val;
  assign sec_adj   = off_neg ? (offs_wrap ? '0 : '1)
                             : (offs_wrap ? 32'd1 : 32'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      sub_q <= '0;
    end else if (do_load) begin
      sec_q <= off_sec;
      sub_q <= off_sub;
    end else if (do_offs) begin
      sec_q <= sec_q + off_sec + sec_adj;
      sub_q <= offs_wrap ? SUB_W'(offs_sum - wrap_val) : SUB_W'(offs_sum);
    end else if (step) begin
      if (tick_wrap) begin
        sec_q <= sec_q + 32'd1;
        sub_q <= SUB_W'(tick_sum - wrap_val);
      end else begin
        sub_q <= SUB_W'(tick_sum);
      end
    end
  end

  AST_WRAP_CARRIES: assert property (@(posedge clk) disable iff (rst)
    (!do_load && !do_offs && step && tick_wrap) |=>
      (sec_q == $past(sec_q) + 32'd1) && (sub_q < $past(sub_q) + 31'd1)); // R4
  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (!do_load && !do_offs && step && !tick_wrap) |=>
      $stable(sec_q) && (32'(sub_q) == 32'($past(sub_q)) + 32'($past(inc)))); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    do_load |=> (sec_q == $past(off_sec)) && (sub_q == $past(off_sub))); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!do_load && !do_offs && !step) |=> $stable(sec_q) && $stable(sub_q)); // R3
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int INC_W = 8,
  parameter int INC_SHIFTED = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [2:0]        rd_addr,
  output logic [31:0]       rd_data
);
  localparam int INC_POS = (INC_SHIFTED != 0) ? 16 : 0;

  logic              fine, dec, off_neg, step;
  logic [INC_W-1:0]  inc;
  logic [WORD_W-1:0] off_sec, addend_stage, sec_q;
  logic [SUB_W-1:0]  off_sub, sub_q;
  cmd_t              run;

  tod_regs #(.INC_W(INC_W), .INC_POS(INC_POS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .t_sec(sec_q), .t_sub(sub_q), .fine(fine), .dec(dec),
    .inc(inc), .off_sec(off_sec), .off_sub(off_sub), .off_neg(off_neg),
    .addend_stage(addend_stage), .run(run), .rd_data(rd_data)
  );

  tod_rate #(.ACC_W(WORD_W)) u_rate (
    .clk(clk), .rst(rst), .fine(fine), .take_addend(run.addc),
    .addend_stage(addend_stage), .step(step)
  );

  tod_clock #(.INC_W(INC_W)) u_clock (
    .clk(clk), .rst(rst), .dec(dec), .inc(inc), .step(step),
    .do_load(run.load), .do_offs(run.offs), .off_sec(off_sec),
    .off_sub(off_sub), .off_neg(off_neg), .sec_q(sec_q), .sub_q(sub_q)
  );

  AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == 3'd7) |-> (rd_data == 32'd0)); // R12
endmodule

// File: tb/tod_counter_tb.sv
module tod_counter_tb;
  localparam int SHIFT = 1;
  localparam longint TWO32 = 64'h1_0000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit started = 0, done = 0;
  string phase = "R1";

  tod_counter #(.INC_W(8), .INC_SHIFTED(SHIFT)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  // behavioural model state
  bit m_fine, m_dec, m_pl, m_po, m_pa, m_neg;
  longint m_inc, m_osec, m_osub, m_stage, m_act, m_acc, m_sec, m_sub;
  logic [31:0] exp_rd;

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {27'd0, m_pa, m_po, m_pl, m_dec, m_fine};
      3'd1: return 32'(m_inc << (SHIFT ? 16 : 0));
      3'd2: return 32'(m_osec);
      3'd3: return {m_neg, 31'(m_osub)};
      3'd4: return 32'(m_stage);
      3'd5: return 32'(m_sec);
      3'd6: return 32'(m_sub);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {m_fine, m_dec, m_pl, m_po, m_pa, m_neg} = '0;
      m_inc = 0; m_osec = 0; m_osub = 0; m_stage = 0;
      m_act = 0; m_acc = 0; m_sec = 0; m_sub = 0;
      exp_rd = '0;
    end else begin
      bit go_l, go_o, go_a, carry;
      longint wrapv, s, n;
      exp_rd = model_read(rd_addr);
      go_l = m_pl; go_o = m_po && !m_pl; go_a = m_pa && !m_pl && !m_po;
      wrapv = m_dec ? 1000000000 : 64'h8000_0000;
      carry = 1;
      if (m_fine) begin
        s = m_acc + m_act;
        carry = (s >= TWO32);
        m_acc = s % TWO32;
      end
      if (go_l) begin
        m_sec = m_osec; m_sub = m_osub;
      end else if (go_o) begin
        if (!m_neg) begin
          s = m_sub + m_osub;
          m_sub = s % wrapv;
          m_sec = (m_sec + m_osec + s / wrapv) % TWO32;
        end else begin
          s = (TWO32 - m_osec) % TWO32;
          n = wrapv - m_osub;
          if (m_sub >= n) m_sub = m_sub - n;
          else begin
            m_sub = m_sub + wrapv - n;
            m_sec = (m_sec + TWO32 - 1) % TWO32;
          end
          m_sec = (m_sec + TWO32 - s) % TWO32;
        end
      end else if (carry) begin
        m_sub = m_sub + m_inc;
        if (m_sub >= wrapv) begin
          m_sub = m_sub - wrapv;
          m_sec = (m_sec + 1) % TWO32;
        end
      end
      if (go_a) m_act = m_stage;
      if (go_l) m_pl = 0;
      if (go_o) m_po = 0;
      if (go_a) m_pa = 0;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin
            m_fine = wr_data[0]; m_dec = wr_data[1];
            m_pl = m_pl | wr_data[2]; m_po = m_po | wr_data[3];
            m_pa = m_pa | wr_data[4];
          end
          3'd1: m_inc = longint'((wr_data >> (SHIFT ? 16 : 0)) & 32'hFF);
          3'd2: m_osec = longint'(wr_data);
          3'd3: begin m_osub = longint'(wr_data[30:0]); m_neg = wr_data[31]; end
          3'd4: m_stage = longint'(wr_data);
          default: ;
        endcase
      end
      started = 1;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      n_cmp++;
      if (rd_data !== exp_rd) begin
        n_bad++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", phase,
                 $past(rd_addr), rd_data, exp_rd);
      end
    end
  end

  // read address sweeps every word
  initial begin
    forever begin
      @(negedge clk);
      rd_addr = rd_addr + 3'd1;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000 && !done) begin
        done = 1;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<=50000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    phase = "R1"; idle(16);
    phase = "R11"; wr(3'd1, 32'd30 << 16);
    phase = "R2"; idle(24);
    phase = "R5"; wr(3'd2, 32'd5); wr(3'd3, 32'h7FFF_FF80);
    wr(3'd0, 32'h4); idle(24);
    phase = "R4"; wr(3'd3, 32'd999_999_950); wr(3'd2, 32'd77);
    wr(3'd0, 32'h6); idle(24);
    phase = "R7"; wr(3'd2, 32'd3); wr(3'd3, 32'd999_999_990);
    wr(3'd0, 32'h2 | 32'h8); idle(16);
    phase = "R8"; wr(3'd2, 32'd10); wr(3'd3, 32'd100); wr(3'd0, 32'h6);
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'h8000_0000 | (32'd1_000_000_000 - 32'd500));
    wr(3'd0, 32'h2 | 32'h8); idle(16);
    wr(3'd0, 32'h0); wr(3'd2, 32'hFFFF_FFFE); wr(3'd3, 32'h8000_0000 | 32'h7FFF_FFF0);
    wr(3'd0, 32'h8); idle(16);
    phase = "R9"; wr(3'd4, 32'h8000_0000); wr(3'd0, 32'h2 | 32'h10); idle(8);
    phase = "R3"; wr(3'd1, 32'd20 << 16); wr(3'd0, 32'h3); idle(40);
    wr(3'd4, 32'h4000_0001); wr(3'd0, 32'h3 | 32'h10); idle(60);
    phase = "R10"; wr(3'd2, 32'd42); wr(3'd3, 32'd123); wr(3'd4, 32'hC000_0000);
    wr(3'd0, 32'h3 | 32'h1C); idle(40);
    wr(3'd0, 32'h3 | 32'h18); idle(40);
    phase = "R12"; wr(3'd0, 32'h2); wr(3'd1, 32'd200 << 16);
    wr(3'd3, 32'd999_999_000); wr(3'd0, 32'h6); idle(64);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule